// File: doc/BRIEF.md
# Handshake pin control unit

This block controls two handshake pins that sit beside an 8-bit parallel port. The first pin, the service pin, is bidirectional. It can be a sensed input whose asserted edges set a status flag. It can also be a driven output that is held negated, held asserted, or run as the acknowledge side of an input handshake. That handshake is either interlocked or pulsed, and it is paced by the second pin, an input strobe. The block also computes an occupancy status flag from two full indicators that the data path supplies for its output latches. A control bit chooses between two reporting rules for that flag.

Software programs the block through a 6-bit control word. The word is written with one strobe and has this layout:

- bits [5:3]: pin function field
- bit 2: edge-interrupt enable
- bit 1: occupancy service enable, gating both the interrupt and the DMA request
- bit 0: occupancy rule select

The edge flag is cleared by writing a 1 on a separate clear port. Both pin inputs pass through a synchronizer of `SYNC_STAGES` flops before edge detection. The asserted pin level is set by the `ACTIVE_LOW` parameter, which defaults to active-low.

Top module: `hsk_pin_ctrl`

## Requirements
- R1: With control bit 5 at 0, the service pin is not driven (`hpin_oe`=0). `edge_flag` sets in the `SYNC_STAGES`+1-th clock after the pin moves to its asserted level. A held level, a move to the negated level, or a switch back into this mode while the pin is already asserted does not set it.
- R2: Field [5:3]=100 drives the service pin at its negated level. `edge_flag` is cleared one clock after the field takes effect and stays clear whatever the pin does.
- R3: Field [5:3]=101 drives the service pin at its asserted level, and `edge_flag` stays clear.
- R4: Field [5:3]=110 (interlocked): the driven pin asserts `SYNC_STAGES`+1 clocks after the strobe pin's asserted edge. It stays asserted until the strobe's return to its negated level is seen, `SYNC_STAGES`+1 clocks after that return.
- R5: Field [5:3]=111 (pulsed): the driven pin asserts for exactly one clock, `SYNC_STAGES`+1 clocks after each asserted strobe edge.
- R6: Writing 1 on the clear port clears `edge_flag`, and writing 0 has no effect. If a clear and an asserted edge land on the same clock, the flag ends set.
- R7: `edge_irq` is high exactly when `edge_flag` is set and control bit 2 is 1.
- R8: `occ_irq` and `dma_req` both equal `occ_flag` when control bit 1 is 1, and are both 0 when it is 0.
- R9: With control bit 0 at 0, `occ_flag` is 1 unless both latch-full inputs are 1.
- R10: With control bit 0 at 1, `occ_flag` is 1 only when both latch-full inputs are 0.
- R11: Reset sets the control word to zero, clears `edge_flag` and the handshake state, releases the service pin, and holds `hpin_out` at the negated level.
- R12: With `ACTIVE_LOW`=1, the asserted level is 0 on both pin inputs and on `hpin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| clr_we | input | 1 | Edge flag clear write strobe |
| clr_data | input | 1 | Clear data; 1 clears the edge flag |
| hpin_in | input | 1 | Service pin level as seen at the pad |
| hpin_out | output | 1 | Service pin drive level |
| hpin_oe | output | 1 | Service pin output enable |
| stb_in | input | 1 | Strobe pin level |
| lat_first_full | input | 1 | First output latch is full |
| lat_second_full | input | 1 | Second output latch is full |
| edge_flag | output | 1 | Service pin edge status flag |
| occ_flag | output | 1 | Latch occupancy status flag |
| edge_irq | output | 1 | Edge interrupt request |
| occ_irq | output | 1 | Occupancy interrupt request |
| dma_req | output | 1 | Occupancy DMA request |

## Verification
The bench targets the clock on which an asserted edge and a write-1 clear meet. A design that lets the clear win drops that edge, and `edge_flag` reads 0. It checks the exact latency and width of the pulsed acknowledge. Off-by-one synchronizer accounting, or a pulse that lingers, shows up as the pin asserted one clock early, one clock late, or for two clocks. It checks that the interlocked acknowledge holds through a long strobe and releases only after the strobe is released. It also returns to sense mode with the pin already asserted, where an edge detector that stops tracking in output modes would raise a false flag. A table sweeps every occupancy rule, enable and latch-full combination, so a swapped rule or a missing gate on the DMA request shows up as a wrong flag or request.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int CTL_W = 6;

    // Control word; member order fixes the bit positions [5:3],[2],[1],[0].
    typedef struct packed {
        logic [2:0] pin_mode;
        logic       edge_ie;
        logic       occ_en;
        logic       occ_all_empty;
    } ctl_t;

    typedef enum logic [2:0] {
        FN_SENSE,
        FN_HOLD_NEG,
        FN_HOLD_ASRT,
        FN_ILOCK,
        FN_PULSE
    } pin_fn_e;

    function automatic pin_fn_e decode_fn(input logic [2:0] mode);
        pin_fn_e fn;
        if (!mode[2]) begin
            fn = FN_SENSE;
        end else begin
            case (mode[1:0])
                2'b00:   fn = FN_HOLD_NEG;
                2'b01:   fn = FN_HOLD_ASRT;
                2'b10:   fn = FN_ILOCK;
                default: fn = FN_PULSE;
            endcase
        end
        return fn;
    endfunction

    function automatic logic drives_pin(input pin_fn_e fn);
        return fn != FN_SENSE;
    endfunction

    // Physical level for a logical assertion under the chosen polarity.
    function automatic logic level_of(input logic asrt, input bit active_low);
        return asrt ^ active_low;
    endfunction

endpackage

// File: rtl/hsk_sync_edge.sv
module hsk_sync_edge #(
    parameter int STAGES     = 2,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic rise,
    output logic fall
);
    localparam logic IDLE_LVL = ACTIVE_LOW;

    logic [STAGES-1:0] chain_q;
    logic              asrt;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= IDLE_LVL;
                else     chain_q <= pin_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{IDLE_LVL}};
                else     chain_q <= {chain_q[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    assign asrt = chain_q[STAGES-1] ^ ACTIVE_LOW;

    // Tracks the synchronized level in every mode, so no stale edge survives a mode change.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= asrt;
    end

    assign rise = asrt & ~prev_q;
    assign fall = ~asrt & prev_q;

endmodule

// File: rtl/hsk_ack_drive.sv
module hsk_ack_drive
    import hsk_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  pin_fn_e fn,
    input  logic    stb_rise,
    input  logic    stb_fall,
    output logic    pin_out,
    output logic    pin_oe
);
    logic ack_q;
    logic ack_d;
    logic asrt_now;

    always_comb begin
        case (fn)
            FN_ILOCK: ack_d = stb_rise | (ack_q & ~stb_fall);
            FN_PULSE: ack_d = stb_rise;
            default:  ack_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= ack_d;
    end

    always_comb begin
        case (fn)
            FN_HOLD_ASRT:       asrt_now = 1'b1;
            FN_ILOCK, FN_PULSE: asrt_now = ack_q;
            default:            asrt_now = 1'b0;
        endcase
    end

    assign pin_out = level_of(asrt_now, ACTIVE_LOW);
    assign pin_oe  = drives_pin(fn);

endmodule

// File: rtl/hsk_occ_flag.sv
module hsk_occ_flag (
    input  logic all_empty_rule,
    input  logic first_full,
    input  logic second_full,
    output logic flag
);
    logic room_any;
    logic room_all;

    assign room_any = ~(first_full & second_full);
    assign room_all = ~first_full & ~second_full;
    assign flag     = all_empty_rule ? room_all : room_any;

endmodule

// File: rtl/hsk_pin_ctrl.sv
module hsk_pin_ctrl
    import hsk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             clr_we,
    input  logic             clr_data,
    input  logic             hpin_in,
    output logic             hpin_out,
    output logic             hpin_oe,
    input  logic             stb_in,
    input  logic             lat_first_full,
    input  logic             lat_second_full,
    output logic             edge_flag,
    output logic             occ_flag,
    output logic             edge_irq,
    output logic             occ_irq,
    output logic             dma_req
);
    localparam int NPINS   = 2;
    localparam int IDX_SVC = 0;
    localparam int IDX_STB = 1;

    ctl_t              ctl_q;
    pin_fn_e           fn;
    logic [NPINS-1:0]  pin_raw;
    logic [NPINS-1:0]  pin_rise;
    logic [NPINS-1:0]  pin_fall;
    logic              flag_q;
    logic              flag_d;
    logic              clr_hit;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
    end

    assign fn = decode_fn(ctl_q.pin_mode);

    assign pin_raw[IDX_SVC] = hpin_in;
    assign pin_raw[IDX_STB] = stb_in;

    generate
        for (genvar g = 0; g < NPINS; g++) begin : g_pin
            hsk_sync_edge #(
                .STAGES     (SYNC_STAGES),
                .ACTIVE_LOW (ACTIVE_LOW)
            ) u_sync (
                .clk     (clk),
                .rst     (rst),
                .pin_raw (pin_raw[g]),
                .rise    (pin_rise[g]),
                .fall    (pin_fall[g])
            );
        end
    endgenerate

    // Edge status: a new edge outranks a simultaneous write-1 clear.
    assign clr_hit = clr_we & clr_data;

    always_comb begin
        if (drives_pin(fn)) flag_d = 1'b0;
        else                flag_d = pin_rise[IDX_SVC] | (flag_q & ~clr_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    hsk_ack_drive #(
        .ACTIVE_LOW (ACTIVE_LOW)
    ) u_ack (
        .clk      (clk),
        .rst      (rst),
        .fn       (fn),
        .stb_rise (pin_rise[IDX_STB]),
        .stb_fall (pin_fall[IDX_STB]),
        .pin_out  (hpin_out),
        .pin_oe   (hpin_oe)
    );

    hsk_occ_flag u_occ (
        .all_empty_rule (ctl_q.occ_all_empty),
        .first_full     (lat_first_full),
        .second_full    (lat_second_full),
        .flag           (occ_flag)
    );

    assign edge_flag = flag_q;
    assign edge_irq  = flag_q & ctl_q.edge_ie;
    assign occ_irq   = occ_flag & ctl_q.occ_en;
    assign dma_req   = occ_flag & ctl_q.occ_en;

    logic unused_fall_svc;
    assign unused_fall_svc = pin_fall[IDX_SVC];

endmodule

// File: rtl/hsk_pin_ctrl_chk.sv
module hsk_pin_ctrl_chk
    import hsk_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic clk,
    input logic rst,
    input ctl_t ctl_q,
    input logic hpin_out,
    input logic hpin_oe,
    input logic lat_first_full,
    input logic lat_second_full,
    input logic edge_flag,
    input logic occ_flag,
    input logic edge_irq,
    input logic occ_irq,
    input logic dma_req
);
    localparam logic ASRT_LVL = ~ACTIVE_LOW;
    localparam logic NEG_LVL  = ACTIVE_LOW;

    a_r1_sense_released: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.pin_mode[2] |-> !hpin_oe);

    a_r2_hold_negated: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pin_mode == 3'b100) |-> (hpin_oe && hpin_out == NEG_LVL));

    a_r2_flag_clear_when_driven: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pin_mode[2] && $past(ctl_q.pin_mode[2])) |-> !edge_flag);

    a_r3_hold_asserted: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pin_mode == 3'b101) |-> (hpin_oe && hpin_out == ASRT_LVL));

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pin_mode == 3'b111 && hpin_out == ASRT_LVL)
        |=> (ctl_q.pin_mode != 3'b111 || hpin_out == NEG_LVL));

    a_r7_edge_irq_gated: assert property (@(posedge clk) disable iff (rst)
        edge_irq |-> (edge_flag && ctl_q.edge_ie));

    a_r8_occ_req_gated: assert property (@(posedge clk) disable iff (rst)
        (occ_irq || dma_req) |-> (ctl_q.occ_en && occ_flag));

    a_r9_any_room: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.occ_all_empty && !(lat_first_full && lat_second_full)) |-> occ_flag);

    a_r10_all_empty: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.occ_all_empty && (lat_first_full || lat_second_full)) |-> !occ_flag);

endmodule

bind hsk_pin_ctrl hsk_pin_ctrl_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ctl_q           (ctl_q),
    .hpin_out        (hpin_out),
    .hpin_oe         (hpin_oe),
    .lat_first_full  (lat_first_full),
    .lat_second_full (lat_second_full),
    .edge_flag       (edge_flag),
    .occ_flag        (occ_flag),
    .edge_irq        (edge_irq),
    .occ_irq         (occ_irq),
    .dma_req         (dma_req)
);

// File: tb/hsk_pin_ctrl_tb.sv
module hsk_pin_ctrl_tb;

    localparam logic AL = 1'b0;  // asserted level, ACTIVE_LOW default
    localparam logic NL = 1'b1;  // negated level

    // {rule, en, first_full, second_full, exp_flag, exp_irq, exp_dma}
    localparam logic [6:0] VEC [16] = '{
        7'b0000_100, 7'b0001_100, 7'b0010_100, 7'b0011_000,
        7'b0100_111, 7'b0101_111, 7'b0110_111, 7'b0111_000,
        7'b1000_100, 7'b1001_000, 7'b1010_000, 7'b1011_000,
        7'b1100_111, 7'b1101_000, 7'b1110_000, 7'b1111_000
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       clr_we = 1'b0;
    logic       clr_data = 1'b0;
    logic       hpin_in = NL;
    logic       stb_in = NL;
    logic       lat_first_full = 1'b0;
    logic       lat_second_full = 1'b0;
    logic       hpin_out, hpin_oe, edge_flag, occ_flag, edge_irq, occ_irq, dma_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hsk_pin_ctrl u_dut (
        .clk             (clk),
        .rst             (rst),
        .ctl_we          (ctl_we),
        .ctl_wdata       (ctl_wdata),
        .clr_we          (clr_we),
        .clr_data        (clr_data),
        .hpin_in         (hpin_in),
        .hpin_out        (hpin_out),
        .hpin_oe         (hpin_oe),
        .stb_in          (stb_in),
        .lat_first_full  (lat_first_full),
        .lat_second_full (lat_second_full),
        .edge_flag       (edge_flag),
        .occ_flag        (occ_flag),
        .edge_irq        (edge_irq),
        .occ_irq         (occ_irq),
        .dma_req         (dma_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_we = 1'b1;
        ctl_wdata = v;
        tick(1);
        ctl_we = 1'b0;
    endtask

    task automatic clr(input logic d);
        clr_we = 1'b1;
        clr_data = d;
        tick(1);
        clr_we = 1'b0;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R11 reset state
        chk("R11", "oe after reset", hpin_oe, 1'b0);
        chk("R11", "pin_out after reset", hpin_out, NL);
        chk("R11", "edge_flag after reset", edge_flag, 1'b0);
        chk("R11", "occ_irq after reset", occ_irq, 1'b0);
        chk("R11", "dma_req after reset", dma_req, 1'b0);

        // R8 R9 R10 occupancy table
        for (int i = 0; i < 16; i++) begin
            wr_ctl({3'b000, 1'b0, VEC[i][5], VEC[i][6]});
            lat_first_full  = VEC[i][4];
            lat_second_full = VEC[i][3];
            tick(1);
            chk(VEC[i][6] ? "R10" : "R9", $sformatf("occ_flag vec %0d", i), occ_flag, VEC[i][2]);
            chk("R8", $sformatf("occ_irq vec %0d", i), occ_irq, VEC[i][1]);
            chk("R8", $sformatf("dma_req vec %0d", i), dma_req, VEC[i][0]);
        end
        lat_first_full = 1'b0;
        lat_second_full = 1'b0;

        // R1 sense mode, edge latency; R12 asserted level is low
        wr_ctl(6'b000_100);
        chk("R1", "oe in sense mode", hpin_oe, 1'b0);
        hpin_in = AL;
        tick(2);
        chk("R1", "flag before latency", edge_flag, 1'b0);
        tick(1);
        chk("R12", "flag on low-going edge", edge_flag, 1'b1);
        chk("R7", "edge_irq enabled", edge_irq, 1'b1);

        clr(1'b1);
        chk("R6", "flag after write 1", edge_flag, 1'b0);
        tick(4);
        chk("R1", "held level no reset", edge_flag, 1'b0);
        hpin_in = NL;
        tick(4);
        chk("R1", "negated edge no set", edge_flag, 1'b0);
        hpin_in = AL;
        tick(3);
        chk("R1", "second edge sets", edge_flag, 1'b1);
        clr(1'b0);
        chk("R6", "write 0 no effect", edge_flag, 1'b1);
        wr_ctl(6'b000_000);
        chk("R7", "edge_irq disabled", edge_irq, 1'b0);
        chk("R7", "flag kept when disabled", edge_flag, 1'b1);

        // R6 edge and clear on the same clock
        clr(1'b1);
        hpin_in = NL;
        tick(4);
        hpin_in = AL;
        tick(2);
        chk("R6", "flag before collision", edge_flag, 1'b0);
        clr_we = 1'b1;
        clr_data = 1'b1;
        tick(1);
        clr_we = 1'b0;
        chk("R6", "edge wins over clear", edge_flag, 1'b1);

        // R2 hold negated
        wr_ctl(6'b100_000);
        chk("R2", "oe", hpin_oe, 1'b1);
        chk("R2", "pin negated", hpin_out, NL);
        tick(1);
        chk("R2", "flag cleared", edge_flag, 1'b0);
        hpin_in = NL;
        tick(4);
        hpin_in = AL;
        tick(4);
        chk("R2", "flag stays clear", edge_flag, 1'b0);

        // R3 hold asserted
        wr_ctl(6'b101_000);
        chk("R3", "oe", hpin_oe, 1'b1);
        chk("R12", "pin asserted is low", hpin_out, AL);
        chk("R3", "flag clear", edge_flag, 1'b0);

        // R4 interlocked
        wr_ctl(6'b110_000);
        chk("R4", "idle negated", hpin_out, NL);
        stb_in = AL;
        tick(2);
        chk("R4", "before latency", hpin_out, NL);
        tick(1);
        chk("R4", "asserted after strobe", hpin_out, AL);
        tick(5);
        chk("R4", "held during strobe", hpin_out, AL);
        stb_in = NL;
        tick(2);
        chk("R4", "held before release seen", hpin_out, AL);
        tick(1);
        chk("R4", "released", hpin_out, NL);

        // R5 pulsed
        wr_ctl(6'b111_000);
        chk("R5", "idle negated", hpin_out, NL);
        stb_in = AL;
        tick(3);
        chk("R5", "pulse asserted", hpin_out, AL);
        tick(1);
        chk("R5", "pulse one clock", hpin_out, NL);
        tick(3);
        chk("R5", "stays negated", hpin_out, NL);
        stb_in = NL;
        tick(4);

        // R1 return to sense with pin already asserted
        wr_ctl(6'b000_100);
        tick(4);
        chk("R1", "no false edge on mode switch", edge_flag, 1'b0);

        // R11 reset mid-run
        wr_ctl(6'b101_100);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R11", "oe after mid reset", hpin_oe, 1'b0);
        chk("R11", "pin_out after mid reset", hpin_out, NL);

        finish_run();
    end

endmodule